// File: doc/BRIEF.md
# Multi-Channel Reload Timer Unit

This block is a register-mapped timer unit with four counters behind a simple APB-style read/write port. Three of the counters are reload channels. Two of them are 16 bits wide and one is 32 bits wide. Each reload channel counts down on a tick strobe and reloads or wraps when it underflows. Each one also raises its own interrupt line, and that line stays high until software writes the channel's clear register. The fourth counter is 40 bits wide and counts up freely on a separate, faster tick strobe. It has no interrupt, and a flag in its upper word turns it on or off.

The tick strobes come in as single-cycle enable inputs; this block does not divide them from the system clock. Each reload channel selects either the main tick or a slower alternate tick. Typical use has software stop a channel, program its load value, then start it in periodic mode to get a steady interrupt every load+1 ticks. The 40-bit counter serves as a fine-grained timestamp.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every load, value and control register reads zero, all three interrupt outputs are low, and the 40-bit counter is disabled at zero.
- R2: A load-register write to a stopped channel also sets its value. The same write to a running channel leaves the value untouched, and the new load applies at the next reload.
- R3: A running channel decrements by one on each selected tick. Control bit 3 = 1 selects the main tick, and bit 3 = 0 selects the alternate tick. The tick that is not selected has no effect.
- R4: In periodic mode (control bit 6 = 1), a running channel that underflows from zero reloads from its load register. A load of N therefore gives a period of N+1 ticks.
- R5: In non-periodic mode (control bit 6 = 0), an underflow wraps the value to all ones of the channel width: 0xFFFF for 16-bit channels and 0xFFFFFFFF for the 32-bit channel.
- R6: An underflow sets that channel's interrupt output (irq_o bit 0, 1 and 2 for channels 1, 2 and 3). The output stays high until any write to the channel's clear register at offset base+0x0C. The clear register reads zero.
- R7: While control bit 7 (run) is 0, a channel holds its value and raises no interrupt.
- R8: A control register reads back only bits 7, 6 and 3 of what was written; every other bit reads zero.
- R9: Bit 8 of the upper-word register (0x64) enables the 40-bit counter, which then increments on each fast tick. The lower word (0x60) reads bits 31:0. The upper word reads bits 39:32 in its low byte and the enable flag in bit 8.
- R10: Channel bases are 0x00, 0x20 and 0x80, with load, value, control and clear at +0x0, +0x4, +0x8 and +0xC. Writes to a value register or to 0x60 are ignored, and unmapped addresses read zero.
- R11: Channels 1 and 2 store and return only 16 bits of load and value, with upper bits zero. Channel 3 stores all 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write (1) or read (0) |
| paddr_i | input | 8 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while selected |
| tick_main_i | input | 1 | Main tick strobe for reload channels |
| tick_alt_i | input | 1 | Alternate slower tick strobe |
| tick_free_i | input | 1 | Fast tick strobe for the 40-bit counter |
| irq_o | output | 3 | Per-channel pending interrupts |

## Verification
The assertions check several properties on every cycle:
- A clear write made with no tick present drops the interrupt.
- An interrupt only rises after a running channel sat at zero.
- A stopped channel neither moves nor raises an interrupt unless its load is written.
- The 40-bit counter steps by exactly one when it is enabled and ticked, and holds otherwise.

Only the bench scenarios can show the rest:
- the actual reload period and the reload value, including a new load that is picked up at the next reload;
- the wrap value in non-periodic mode;
- tick selection between main and alternate;
- control read-back masking and width truncation;
- the behaviour of the address map and of ignored writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH         = 3;
  localparam int CTL_RUN     = 7;
  localparam int CTL_PER     = 6;
  localparam int CTL_SEL     = 3;
  localparam int FREE_EN_BIT = 8;
  localparam logic [7:0] OFF_LOAD = 8'h00;
  localparam logic [7:0] OFF_VAL  = 8'h04;
  localparam logic [7:0] OFF_CTL  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] FREE_LO  = 8'h60;
  localparam logic [7:0] FREE_HI  = 8'h64;

  function automatic logic [7:0] chan_base(int i);
    case (i)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_we_i,
  input  logic         ctl_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] load_i,
  input  logic         run_i,
  input  logic         per_i,
  input  logic         sel_i,
  input  logic         tick_main_i,
  input  logic         tick_alt_i,
  output logic [W-1:0] load_o,
  output logic [W-1:0] val_o,
  output logic [7:0]   ctl_o,
  output logic         run_o,
  output logic         irq_o
);
  logic [W-1:0] load_q, val_q;
  logic         run_q, per_q, sel_q, irq_q;
  logic         tick, step, under;

  assign tick  = sel_q ? tick_main_i : tick_alt_i;
  assign step  = run_q & tick;
  assign under = step & (val_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      val_q  <= '0;
      run_q  <= 1'b0;
      per_q  <= 1'b0;
      sel_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (load_we_i) load_q <= load_i;
      if (ctl_we_i) begin
        run_q <= run_i;
        per_q <= per_i;
        sel_q <= sel_i;
      end
      if (load_we_i && !run_q) val_q <= load_i;
      else if (under)          val_q <= per_q ? load_q : '1;
      else if (step)           val_q <= val_q - 1'b1;
      // a fresh underflow outranks a same-cycle clear
      if (under)         irq_q <= 1'b1;
      else if (clr_we_i) irq_q <= 1'b0;
    end
  end

  assign load_o = load_q;
  assign val_o  = val_q;
  assign run_o  = run_q;
  assign irq_o  = irq_q;
  always_comb begin
    ctl_o                   = '0;
    ctl_o[tmr_pkg::CTL_RUN] = run_q;
    ctl_o[tmr_pkg::CTL_PER] = per_q;
    ctl_o[tmr_pkg::CTL_SEL] = sel_q;
  end
endmodule

// File: rtl/tmr_free.sv
module tmr_free #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         en_o
);
  logic [W-1:0] cnt_q;
  logic         en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_we_i)        en_q  <= en_i;
      if (en_q && tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;
endmodule

// File: rtl/tmr_bus.sv
module tmr_bus
  import tmr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int FW = 40
) (
  input  logic                    psel_i,
  input  logic                    penable_i,
  input  logic                    pwrite_i,
  input  logic [AW-1:0]           paddr_i,
  input  logic [NCH-1:0][DW-1:0]  ch_load_i,
  input  logic [NCH-1:0][DW-1:0]  ch_val_i,
  input  logic [NCH-1:0][7:0]     ch_ctl_i,
  input  logic [FW-1:0]           free_cnt_i,
  input  logic                    free_en_i,
  output logic [NCH-1:0]          load_we_o,
  output logic [NCH-1:0]          ctl_we_o,
  output logic [NCH-1:0]          clr_we_o,
  output logic                    fhi_we_o,
  output logic [DW-1:0]           rdata_o
);
  logic wr;
  logic [DW-1:0] hi_word;

  assign wr = psel_i & penable_i & pwrite_i;

  always_comb begin
    hi_word                 = '0;
    hi_word[FW-DW-1:0]      = free_cnt_i[FW-1:DW];
    hi_word[FREE_EN_BIT]    = free_en_i;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      load_we_o[i] = wr && (paddr_i == AW'(chan_base(i) + OFF_LOAD));
      ctl_we_o[i]  = wr && (paddr_i == AW'(chan_base(i) + OFF_CTL));
      clr_we_o[i]  = wr && (paddr_i == AW'(chan_base(i) + OFF_CLR));
    end
    fhi_we_o = wr && (paddr_i == AW'(FREE_HI));
  end

  always_comb begin
    rdata_o = '0;
    if (psel_i) begin
      for (int i = 0; i < NCH; i++) begin
        if (paddr_i == AW'(chan_base(i) + OFF_LOAD)) rdata_o = ch_load_i[i];
        if (paddr_i == AW'(chan_base(i) + OFF_VAL))  rdata_o = ch_val_i[i];
        if (paddr_i == AW'(chan_base(i) + OFF_CTL))  rdata_o = DW'(ch_ctl_i[i]);
      end
      if (paddr_i == AW'(FREE_LO)) rdata_o = free_cnt_i[DW-1:0];
      if (paddr_i == AW'(FREE_HI)) rdata_o = hi_word;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W = 32,
  parameter int FREE_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic              tick_main_i,
  input  logic              tick_alt_i,
  input  logic              tick_free_i,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0][DATA_W-1:0] ch_load, ch_val;
  logic [NCH-1:0][7:0]        ch_ctl;
  logic [NCH-1:0]             ch_run, load_we, ctl_we, clr_we;
  logic [FREE_W-1:0]          free_cnt;
  logic                       free_en, fhi_we;

  tmr_bus #(.AW(ADDR_W), .DW(DATA_W), .FW(FREE_W)) u_bus (
    .psel_i, .penable_i, .pwrite_i, .paddr_i,
    .ch_load_i(ch_load), .ch_val_i(ch_val), .ch_ctl_i(ch_ctl),
    .free_cnt_i(free_cnt), .free_en_i(free_en),
    .load_we_o(load_we), .ctl_we_o(ctl_we), .clr_we_o(clr_we),
    .fhi_we_o(fhi_we), .rdata_o(prdata_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int W = (g == NCH - 1) ? WIDE_W : NARROW_W;
    logic [W-1:0] load_w, val_w;
    tmr_chan #(.W(W)) u_ch (
      .clk_i, .rst_ni,
      .load_we_i(load_we[g]), .ctl_we_i(ctl_we[g]), .clr_we_i(clr_we[g]),
      .load_i(pwdata_i[W-1:0]),
      .run_i(pwdata_i[CTL_RUN]), .per_i(pwdata_i[CTL_PER]), .sel_i(pwdata_i[CTL_SEL]),
      .tick_main_i, .tick_alt_i,
      .load_o(load_w), .val_o(val_w), .ctl_o(ch_ctl[g]),
      .run_o(ch_run[g]), .irq_o(irq_o[g])
    );
    assign ch_load[g] = DATA_W'(load_w);
    assign ch_val[g]  = DATA_W'(val_w);
  end

  tmr_free #(.W(FREE_W)) u_free (
    .clk_i, .rst_ni,
    .en_we_i(fhi_we), .en_i(pwdata_i[FREE_EN_BIT]), .tick_i(tick_free_i),
    .cnt_o(free_cnt), .en_o(free_en)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int FW = 40
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   psel_i,
  input logic                   penable_i,
  input logic                   pwrite_i,
  input logic [AW-1:0]          paddr_i,
  input logic                   tick_main_i,
  input logic                   tick_alt_i,
  input logic                   tick_free_i,
  input logic [NCH-1:0]         irq_i,
  input logic [NCH-1:0][DW-1:0] ch_val_i,
  input logic [NCH-1:0]         ch_run_i,
  input logic [FW-1:0]          free_cnt_i,
  input logic                   free_en_i
);
  logic wr;
  assign wr = psel_i & penable_i & pwrite_i;

  for (genvar k = 0; k < NCH; k++) begin : g_k
    logic clr_wr, load_wr;
    assign clr_wr  = wr && (paddr_i == AW'(chan_base(k) + OFF_CLR));
    assign load_wr = wr && (paddr_i == AW'(chan_base(k) + OFF_LOAD));

    AST_CLR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr && !tick_main_i && !tick_alt_i |=> !irq_i[k]); // R6
    AST_IRQ_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_i[k]) |-> ($past(ch_val_i[k]) == '0) && $past(ch_run_i[k])); // R6
    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run_i[k] && !load_wr |=> $stable(ch_val_i[k])); // R7
    AST_STOPPED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run_i[k] && !irq_i[k] |=> !irq_i[k]); // R7
  end

  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_en_i && tick_free_i |=> free_cnt_i == $past(free_cnt_i) + FW'(1)); // R9
  AST_FREE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(free_en_i && tick_free_i) |=> $stable(free_cnt_i)); // R9
endmodule

bind tmr_unit tmr_unit_chk #(.AW(ADDR_W), .DW(DATA_W), .FW(FREE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .paddr_i(paddr_i), .tick_main_i(tick_main_i),
  .tick_alt_i(tick_alt_i), .tick_free_i(tick_free_i), .irq_i(irq_o),
  .ch_val_i(ch_val), .ch_run_i(ch_run), .free_cnt_i(free_cnt), .free_en_i(free_en)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        tick_main = 1'b0, tick_alt = 1'b0, tick_free = 1'b0;
  logic [2:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .tick_main_i(tick_main), .tick_alt_i(tick_alt), .tick_free_i(tick_free),
    .irq_o(irq)
  );

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      item_t it;
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: got %h", prdata);
      end else begin
        it = sb_q.pop_front();
        if (prdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h exp %h", it.tag, prdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: got %b exp %b", tag, irq, e);
    end
  endtask

  task automatic pulse_main(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_main = 1'b1;
      @(posedge clk); #1 tick_main = 1'b0;
    end
  endtask

  task automatic pulse_alt(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_alt = 1'b1;
      @(posedge clk); #1 tick_alt = 1'b0;
    end
  endtask

  task automatic pulse_free(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_free = 1'b1;
      @(posedge clk); #1 tick_free = 1'b0;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 ch1 load");
    rd(8'h04, 32'h0, "R1 ch1 value");
    rd(8'h08, 32'h0, "R1 ch1 ctl");
    rd(8'h84, 32'h0, "R1 ch3 value");
    rd(8'h64, 32'h0, "R1 free hi");
    chk_irq(3'b000, "R1");

    // R2 stopped load sets value; R8 ctl readback
    wr(8'h08, 32'h48);
    wr(8'h00, 32'd5);
    rd(8'h04, 32'd5, "R2 stopped load");
    rd(8'h08, 32'h48, "R8 ctl readback");
    wr(8'h28, 32'h7F);
    rd(8'h28, 32'h48, "R8 ctl mask");

    // R7 stopped holds
    pulse_main(3);
    rd(8'h04, 32'd5, "R7 stopped holds");
    chk_irq(3'b000, "R7");

    // R4 period N+1, R6 irq set
    wr(8'h08, 32'hC8);
    pulse_main(5);
    rd(8'h04, 32'd0, "R3 count to zero");
    chk_irq(3'b000, "R4 before underflow");
    pulse_main(1);
    rd(8'h04, 32'd5, "R4 reload");
    chk_irq(3'b001, "R6 set");

    // R2 running load leaves value
    wr(8'h00, 32'd9);
    rd(8'h04, 32'd5, "R2 running load");
    pulse_main(1);
    rd(8'h04, 32'd4, "R3 decrement");

    // R6 clear
    wr(8'h0C, 32'h0);
    chk_irq(3'b000, "R6 clear");

    // R10 value write ignored
    wr(8'h04, 32'h77);
    rd(8'h04, 32'd4, "R10 value write ignored");

    // R3 alt tick, R5 wrap on 16-bit
    wr(8'h28, 32'h80);
    pulse_alt(1);
    rd(8'h24, 32'h0000FFFF, "R5 ch2 wrap");
    rd(8'h04, 32'd4, "R3 ch1 ignores alt");
    chk_irq(3'b010, "R5 ch2 irq");
    pulse_alt(1);
    rd(8'h24, 32'h0000FFFE, "R3 alt decrement");
    wr(8'h2C, 32'h1);
    chk_irq(3'b000, "R6 ch2 clear");

    // R11 widths
    wr(8'h80, 32'h12345678);
    rd(8'h84, 32'h12345678, "R11 ch3 value");
    rd(8'h80, 32'h12345678, "R11 ch3 load");
    wr(8'h00, 32'hABCD0003);
    rd(8'h00, 32'h00000003, "R11 ch1 truncated");
    rd(8'h04, 32'd4, "R2 ch1 still running value");

    // R5 32-bit wrap
    wr(8'h80, 32'h0);
    rd(8'h84, 32'h0, "R2 ch3 load zero");
    wr(8'h88, 32'h88);
    pulse_main(1);
    rd(8'h84, 32'hFFFFFFFF, "R5 ch3 wrap");
    rd(8'h04, 32'd3, "R3 ch1 main");
    chk_irq(3'b100, "R5 ch3 irq");
    pulse_main(3);
    rd(8'h04, 32'd0, "R3 ch1 zero");
    pulse_main(1);
    rd(8'h04, 32'd3, "R4 new load at reload");
    rd(8'h84, 32'hFFFFFFFB, "R3 ch3 decrement");
    chk_irq(3'b101, "R6 ch1 ch3");

    // R9 free counter
    pulse_free(3);
    rd(8'h60, 32'h0, "R9 disabled holds");
    wr(8'h64, 32'h100);
    rd(8'h64, 32'h100, "R9 enable flag");
    pulse_free(4);
    rd(8'h60, 32'd4, "R9 counts");
    rd(8'h64, 32'h100, "R9 hi word");
    wr(8'h60, 32'hDEAD);
    rd(8'h60, 32'd4, "R10 low write ignored");
    wr(8'h64, 32'h0);
    pulse_free(2);
    rd(8'h60, 32'd4, "R9 disable holds");
    rd(8'h64, 32'h0, "R9 hi after disable");

    // R10 map
    rd(8'h40, 32'h0, "R10 unmapped");
    rd(8'h0C, 32'h0, "R6 clear reads zero");

    @(posedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard left %0d items", sb_q.size());
    end
    summary();
    $finish;
  end
endmodule